// File: doc/BRIEF.md
# PCI Initiator Transaction Sequencer

This block runs one bus transaction at a time from the initiator side once the bus has been granted. A request carries a 4-bit bus command, an address and the number of data phases wanted. The sequencer opens the transaction with an address phase, then asserts the initiator-ready strobe and walks through the data phases. It samples the target's device-select, target-ready and stop strobes on every rising edge, and it keeps the cycle-frame strobe asserted until the final data phase begins.

Each transaction ends in one of five ways: normal completion, master abort, target abort, retry or disconnect. A master abort happens when no target claims the cycle within a programmable number of clocks. At the end the block emits a one-clock done pulse with a status code and the number of data phases that completed. All bus strobes are active low and come straight from flops. The address/data contents beyond the address, and the command or byte-enable lanes beyond the command, are not modelled.

The request side is a valid/ready port. `req_ready` is high only while the sequencer is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and the command, address and length are captured on that edge. While a transaction runs `req_ready` stays low, so a held `req_valid` simply waits. The done/status outputs are plain pins with no back-pressure.

Top module: `pci_iseq`

## Requirements
- R1: During and directly after reset, `bus_frame_n` and `bus_irdy_n` are 1, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while both bus strobes are deasserted. The clock after acceptance is the address phase: `bus_frame_n`=0, `bus_irdy_n`=1, `bus_addr_phase`=1, `bus_ad_out` = captured address and `bus_cbe_out` = captured command.
- R3: From the clock after the address phase, `bus_irdy_n` is 0. `bus_frame_n` stays 0 while more than one data phase remains and goes to 1 for the final data phase while `bus_irdy_n` stays 0. A data phase completes on an edge where `bus_irdy_n`, `bus_trdy_n` and `bus_devsel_n` are all 0.
- R4: Normal completion happens when the final data phase completes. On the next clock both strobes are 1, and `done` is 1 for exactly one clock with `done_status`=0 and `done_count` = requested length. A length of 0 is treated as 1.
- R5: Let L = `cfg_dsel_limit` raised to a floor of 5. Data clocks are numbered from 1, starting at the clock after the address phase. If `bus_devsel_n` has not been 0 on any edge up to and including the edge ending data clock L, the transaction ends with `done_status`=1 (master abort) and `done_count`=0. A claim on the edge ending data clock L avoids the abort.
- R6: If `bus_stop_n`=0 while `bus_devsel_n`=1 after device-select had been sampled 0 earlier in the transaction, the transaction ends with `done_status`=2 (target abort). `done_count` is the number of phases completed before that edge.
- R7: If `bus_stop_n`=0 with `bus_devsel_n`=0, no data phase has completed yet and none completes on that edge, the transaction ends with `done_status`=3 (retry) and `done_count`=0.
- R8: If `bus_stop_n`=0 with `bus_devsel_n`=0 after at least one data phase has completed, the transaction ends with `done_status`=4 (disconnect). A phase that completes on the stop edge itself is counted. A stop edge that completes the final requested phase is a normal completion instead.
- R9: When a transaction ends while `bus_frame_n` is 0, `bus_frame_n` goes to 1 on the next clock with `bus_irdy_n` held at 0 for that one clock. Both strobes are 1 and `done` is 1 on the clock after that. For a stop, this means the frame strobe is released one clock after stop is sampled.
- R10: On an edge where the target claims the cycle but neither target-ready nor stop is asserted (a wait state), `bus_frame_n` keeps its value and `bus_irdy_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dsel_limit | input | TO_W | Device-select timeout in data clocks (floor 5) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_cmd | input | 4 | Bus command for the address phase |
| req_addr | input | ADDR_W | Transaction address |
| req_len | input | LEN_W | Number of data phases (0 treated as 1) |
| bus_frame_n | output | 1 | Cycle frame strobe, active low |
| bus_irdy_n | output | 1 | Initiator ready strobe, active low |
| bus_addr_phase | output | 1 | High during the address phase clock |
| bus_ad_out | output | ADDR_W | Address during the address phase, else 0 |
| bus_cbe_out | output | 4 | Command during the address phase, else 0 (all lanes enabled) |
| bus_devsel_n | input | 1 | Target claim strobe, active low |
| bus_trdy_n | input | 1 | Target ready strobe, active low |
| bus_stop_n | input | 1 | Target stop request, active low |
| done | output | 1 | One-clock end-of-transaction pulse |
| done_status | output | 3 | 0 ok, 1 master abort, 2 target abort, 3 retry, 4 disconnect |
| done_count | output | LEN_W | Data phases completed |

## Verification
The address phase appears one clock after the accepting edge, and data clock k is the k-th clock after that. A plain transaction claimed on its first data clock with no waits raises `done` at clock length+1. A master abort raises `done` at clock L+2, or L+1 for a one-phase request. A retry claimed on clock d raises `done` at clock d+2. The bench drives the target strobes on falling edges and samples every output on the next falling edge. Each protocol check therefore compares the strobes just sampled against the outputs registered one edge later. A scoreboard queue holds the expected status and count of each request and is popped on the done pulse. The driver also counts clocks from the address phase to `done` and compares the count with these latencies.

// File: rtl/pci_iseq_pkg.sv
package pci_iseq_pkg;
  typedef enum logic [2:0] {
    TERM_OK     = 3'd0,
    TERM_MABORT = 3'd1,
    TERM_TABORT = 3'd2,
    TERM_RETRY  = 3'd3,
    TERM_DISC   = 3'd4
  } term_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_DRAIN
  } phase_t;

  localparam int unsigned MIN_DSEL_LIMIT = 5;
endpackage

// File: rtl/pci_iseq_dsel_watch.sv
module pci_iseq_dsel_watch
  import pci_iseq_pkg::*;
#(
  parameter int unsigned TO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            track,
  input  logic            dev_now,
  input  logic [TO_W-1:0] cfg_limit,
  output logic            seen,
  output logic            expired
);
  localparam logic [TO_W-1:0] FLOOR   = TO_W'(MIN_DSEL_LIMIT);
  localparam logic [TO_W-1:0] CNT_TOP = '1;

  logic [TO_W-1:0] clk_cnt_q;
  logic [TO_W-1:0] limit;
  logic            seen_q;

  always_comb limit = (cfg_limit < FLOOR) ? FLOOR : cfg_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cnt_q <= '0;
      seen_q    <= 1'b0;
    end else if (arm) begin
      clk_cnt_q <= TO_W'(1);
      seen_q    <= 1'b0;
    end else if (track) begin
      if (clk_cnt_q != CNT_TOP) clk_cnt_q <= clk_cnt_q + TO_W'(1);
      seen_q <= seen_q | dev_now;
    end
  end

  assign seen    = seen_q;
  assign expired = !seen_q && !dev_now && (clk_cnt_q >= limit);
endmodule

// File: rtl/pci_iseq_phase_track.sv
module pci_iseq_phase_track #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             step,
  output logic [LEN_W-1:0] left,
  output logic [LEN_W-1:0] done_cnt,
  output logic             last
);
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= LEN_W'(1);
      cnt_q  <= '0;
    end else if (load) begin
      left_q <= (len_in == '0) ? LEN_W'(1) : len_in;
      cnt_q  <= '0;
    end else if (step) begin
      if (left_q != '0) left_q <= left_q - LEN_W'(1);
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign left     = left_q;
  assign done_cnt = cnt_q;
  assign last     = (left_q == LEN_W'(1));
endmodule

// File: rtl/pci_iseq_classify.sv
module pci_iseq_classify
  import pci_iseq_pkg::*;
(
  input  logic  xfer,
  input  logic  last,
  input  logic  stop,
  input  logic  dev,
  input  logic  seen,
  input  logic  expired,
  input  logic  any_done,
  output logic  finish,
  output term_t code,
  output logic  add_one
);
  always_comb begin
    finish  = 1'b0;
    code    = TERM_OK;
    add_one = xfer;
    if (xfer && last) begin
      finish = 1'b1;
      code   = TERM_OK;
    end else if (stop && dev) begin
      finish = 1'b1;
      code   = (!any_done && !xfer) ? TERM_RETRY : TERM_DISC;
    end else if (stop && !dev && seen) begin
      finish = 1'b1;
      code   = TERM_TABORT;
    end else if (expired) begin
      finish = 1'b1;
      code   = TERM_MABORT;
    end
  end
endmodule

// File: rtl/pci_iseq.sv
module pci_iseq
  import pci_iseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned TO_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TO_W-1:0]   cfg_dsel_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              bus_frame_n,
  output logic              bus_irdy_n,
  output logic              bus_addr_phase,
  output logic [ADDR_W-1:0] bus_ad_out,
  output logic [3:0]        bus_cbe_out,
  input  logic              bus_devsel_n,
  input  logic              bus_trdy_n,
  input  logic              bus_stop_n,
  output logic              done,
  output logic [2:0]        done_status,
  output logic [LEN_W-1:0]  done_count
);
  phase_t            state_q;
  logic              frame_n_q, irdy_n_q, done_q;
  logic [ADDR_W-1:0] ad_q;
  logic [3:0]        cbe_q;
  term_t             status_q;
  logic [LEN_W-1:0]  count_q;

  logic in_data, dev, trdy, stop, xfer;
  logic seen, expired;
  logic [LEN_W-1:0] left, done_cnt;
  logic last;
  logic cls_finish, cls_add;
  term_t cls_code;

  assign in_data = (state_q == PH_DATA);
  assign dev     = in_data && !bus_devsel_n;
  assign trdy    = in_data && !bus_trdy_n;
  assign stop    = in_data && !bus_stop_n;
  assign xfer    = dev && trdy;

  pci_iseq_dsel_watch #(.TO_W(TO_W)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (state_q == PH_ADDR),
    .track     (in_data),
    .dev_now   (dev),
    .cfg_limit (cfg_dsel_limit),
    .seen      (seen),
    .expired   (expired)
  );

  pci_iseq_phase_track #(.LEN_W(LEN_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     ((state_q == PH_IDLE) && req_valid),
    .len_in   (req_len),
    .step     (xfer),
    .left     (left),
    .done_cnt (done_cnt),
    .last     (last)
  );

  pci_iseq_classify u_cls (
    .xfer     (xfer),
    .last     (last),
    .stop     (stop),
    .dev      (dev),
    .seen     (seen),
    .expired  (expired),
    .any_done (done_cnt != '0),
    .finish   (cls_finish),
    .code     (cls_code),
    .add_one  (cls_add)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      frame_n_q <= 1'b1;
      irdy_n_q  <= 1'b1;
      done_q    <= 1'b0;
      ad_q      <= '0;
      cbe_q     <= '0;
      status_q  <= TERM_OK;
      count_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PH_IDLE: begin
          if (req_valid) begin
            state_q   <= PH_ADDR;
            frame_n_q <= 1'b0;
            ad_q      <= req_addr;
            cbe_q     <= req_cmd;
          end
        end
        PH_ADDR: begin
          state_q   <= PH_DATA;
          irdy_n_q  <= 1'b0;
          frame_n_q <= last;
          ad_q      <= '0;
          cbe_q     <= '0;
        end
        PH_DATA: begin
          if (cls_finish) begin
            status_q <= cls_code;
            count_q  <= done_cnt + LEN_W'(cls_add);
            if (!frame_n_q) begin
              state_q   <= PH_DRAIN;
              frame_n_q <= 1'b1;
            end else begin
              state_q  <= PH_IDLE;
              irdy_n_q <= 1'b1;
              done_q   <= 1'b1;
            end
          end else if (xfer && (left == LEN_W'(2))) begin
            frame_n_q <= 1'b1;
          end
        end
        PH_DRAIN: begin
          state_q  <= PH_IDLE;
          irdy_n_q <= 1'b1;
          done_q   <= 1'b1;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == PH_IDLE);
  assign bus_frame_n    = frame_n_q;
  assign bus_irdy_n     = irdy_n_q;
  assign bus_addr_phase = (state_q == PH_ADDR);
  assign bus_ad_out     = ad_q;
  assign bus_cbe_out    = cbe_q;
  assign done           = done_q;
  assign done_status    = status_q;
  assign done_count     = count_q;
endmodule

// File: rtl/pci_iseq_chk.sv
module pci_iseq_chk #(
  parameter int unsigned LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             bus_frame_n,
  input logic             bus_irdy_n,
  input logic             bus_addr_phase,
  input logic             bus_devsel_n,
  input logic             bus_trdy_n,
  input logic             bus_stop_n,
  input logic             done,
  input logic [2:0]       done_status,
  input logic [LEN_W-1:0] done_count
);
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_frame_n && bus_irdy_n)); // R2

  AST_FRAME_OPENS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_frame_n) |-> (bus_irdy_n && bus_addr_phase)); // R2

  AST_IRDY_HOLDS_AT_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_frame_n) && !$past(bus_irdy_n)) |-> !bus_irdy_n); // R3

  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_frame_n && bus_irdy_n)); // R4

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_MABORT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 3'd1) |-> (done_count == '0)); // R5

  AST_RETRY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 3'd3) |-> (done_count == '0)); // R7

  AST_DISC_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status == 3'd4) |-> (done_count != '0)); // R8

  AST_STOP_RELEASES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_stop_n && !bus_devsel_n && !bus_frame_n && !bus_irdy_n) |=> (bus_frame_n && !bus_irdy_n)); // R9

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_irdy_n && !bus_frame_n && !bus_devsel_n && bus_trdy_n && bus_stop_n) |=> (!bus_irdy_n && $stable(bus_frame_n))); // R10
endmodule

bind pci_iseq pci_iseq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .bus_frame_n    (bus_frame_n),
  .bus_irdy_n     (bus_irdy_n),
  .bus_addr_phase (bus_addr_phase),
  .bus_devsel_n   (bus_devsel_n),
  .bus_trdy_n     (bus_trdy_n),
  .bus_stop_n     (bus_stop_n),
  .done           (done),
  .done_status    (done_status),
  .done_count     (done_count)
);

// File: tb/pci_iseq_bench.sv
module pci_iseq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 4;
  localparam int TO_W   = 3;
  localparam int WD_LIMIT = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TO_W-1:0]   cfg_dsel_limit = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [3:0]        req_cmd = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              bus_frame_n, bus_irdy_n, bus_addr_phase;
  logic [ADDR_W-1:0] bus_ad_out;
  logic [3:0]        bus_cbe_out;
  logic              bus_devsel_n = 1'b1;
  logic              bus_trdy_n = 1'b1;
  logic              bus_stop_n = 1'b1;
  logic              done;
  logic [2:0]        done_status;
  logic [LEN_W-1:0]  done_count;

  pci_iseq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TO_W(TO_W)) u_pci_iseq (
    .clk(clk), .rst_n(rst_n), .cfg_dsel_limit(cfg_dsel_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
    .bus_addr_phase(bus_addr_phase), .bus_ad_out(bus_ad_out),
    .bus_cbe_out(bus_cbe_out), .bus_devsel_n(bus_devsel_n),
    .bus_trdy_n(bus_trdy_n), .bus_stop_n(bus_stop_n),
    .done(done), .done_status(done_status), .done_count(done_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  int    exp_st_q[$];
  int    exp_cnt_q[$];
  string exp_tag_q[$];

  // target scenario knobs
  int sc_dev = 0, sc_wait = 0, sc_stop_after = -1, sc_stop_data = 0, sc_tabort = 0;
  int cur_len = 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // target model plus protocol checks
  int dclk = 0, comp = 0, wcnt = 0;
  logic p_frame = 1'b1, p_irdy = 1'b1, p_dev = 1'b1, p_trdy = 1'b1, p_stop = 1'b1;
  bit r9_pend = 1'b0;

  always @(negedge clk) begin
    logic dv, tr, sp;
    bit dev_on;
    if (rst_n) begin
      if (r9_pend) begin
        chk(bus_frame_n && bus_irdy_n && done, "R9", "drain end idle+done",
            int'({bus_frame_n, bus_irdy_n, done}), 7);
        r9_pend = 1'b0;
      end
      if (!p_irdy && !p_frame && !p_dev && !p_stop) begin
        chk(bus_frame_n && !bus_irdy_n, "R9", "frame released irdy held",
            int'({bus_frame_n, bus_irdy_n}), 2);
        r9_pend = 1'b1;
      end
      if (!p_irdy && !p_frame && !p_dev && p_trdy && p_stop)
        chk(!bus_frame_n && !bus_irdy_n, "R10", "wait state holds strobes",
            int'({bus_frame_n, bus_irdy_n}), 0);
      if (!p_irdy && !p_frame && !p_dev && !p_trdy && p_stop && bus_frame_n)
        chk(comp == cur_len - 1 && !bus_irdy_n, "R3", "phases done at final phase", comp, cur_len - 1);
    end
    p_frame = bus_frame_n;
    p_irdy  = bus_irdy_n;
    dv = 1'b1; tr = 1'b1; sp = 1'b1;
    if (rst_n && !bus_irdy_n) begin
      dclk++;
      dev_on = (sc_dev != 0) && (dclk >= sc_dev);
      if (dev_on) begin
        if (sc_stop_after >= 0 && comp == sc_stop_after) begin
          if (sc_tabort != 0) begin
            if (dclk > sc_dev) sp = 1'b0;
            else dv = 1'b0;
          end else begin
            dv = 1'b0; sp = 1'b0;
            if (sc_stop_data != 0) begin tr = 1'b0; comp++; end
          end
        end else begin
          dv = 1'b0;
          if (wcnt == sc_wait) begin tr = 1'b0; comp++; wcnt = 0; end
          else wcnt++;
        end
      end
    end else begin
      dclk = 0; comp = 0; wcnt = 0;
    end
    bus_devsel_n = dv; bus_trdy_n = tr; bus_stop_n = sp;
    p_dev = dv; p_trdy = tr; p_stop = sp;
  end

  // scoreboard monitor and watchdog
  always @(negedge clk) begin
    cycles++;
    if (rst_n && done) begin
      if (exp_st_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected done", 1, 0);
      end else begin
        int es, ec;
        string tg;
        es = exp_st_q.pop_front();
        ec = exp_cnt_q.pop_front();
        tg = exp_tag_q.pop_front();
        chk(int'(done_status) == es, tg, "done_status", int'(done_status), es);
        chk(int'(done_count) == ec, tg, "done_count", int'(done_count), ec);
        chk(bus_frame_n && bus_irdy_n, "R4", "strobes idle at done",
            int'({bus_frame_n, bus_irdy_n}), 3);
      end
    end
    if (cycles > WD_LIMIT) begin
      chk(1'b0, "R4", "watchdog expired", cycles, WD_LIMIT);
      finish_run();
    end
  end

  int txn_no = 0;

  task automatic run_txn(input int cfg, input int len, input int dev, input int wt,
                         input int sa, input int sd, input int ta, input string tag);
    int l_eff, lim, est, ecnt, elat, n;
    logic [ADDR_W-1:0] a;
    logic [3:0] c;
    l_eff = (len == 0) ? 1 : len;
    lim   = (cfg < 5) ? 5 : cfg;
    elat  = -1;
    if (dev == 0 || dev > lim) begin
      est = 1; ecnt = 0; elat = lim + ((l_eff > 1) ? 2 : 1);
    end else if (sa < 0 || sa >= l_eff) begin
      est = 0; ecnt = l_eff;
      if (dev == 1 && wt == 0) elat = l_eff + 1;
    end else if (ta != 0) begin
      est = 2; ecnt = sa;
    end else if (sd != 0) begin
      if (sa + 1 == l_eff) begin est = 0; ecnt = l_eff; end
      else begin est = 4; ecnt = sa + 1; end
    end else begin
      est = (sa == 0) ? 3 : 4; ecnt = sa;
      if (sa == 0 && l_eff > 1) elat = dev + 2;
    end
    exp_st_q.push_back(est);
    exp_cnt_q.push_back(ecnt);
    exp_tag_q.push_back(tag);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sc_dev = dev; sc_wait = wt; sc_stop_after = sa; sc_stop_data = sd; sc_tabort = ta;
    cur_len = l_eff;
    txn_no++;
    a = ADDR_W'(32'h4000_0000 + txn_no * 16);
    c = (txn_no % 2 == 0) ? 4'h6 : 4'h7;
    cfg_dsel_limit = TO_W'(cfg);
    req_addr  = a;
    req_cmd   = c;
    req_len   = LEN_W'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!bus_frame_n && bus_irdy_n && bus_addr_phase && !req_ready, "R2", "address phase strobes",
        int'({bus_frame_n, bus_irdy_n, bus_addr_phase, req_ready}), 4'b0110);
    chk(bus_ad_out == a && bus_cbe_out == c, "R2", "address/command driven",
        int'(bus_cbe_out), int'(c));
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (elat >= 0) chk(n == elat, tag, "clocks to done", n, elat);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_frame_n && bus_irdy_n && req_ready && !done, "R1", "reset state",
        int'({bus_frame_n, bus_irdy_n, req_ready, done}), 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_frame_n && bus_irdy_n && req_ready && !done, "R1", "after reset",
        int'({bus_frame_n, bus_irdy_n, req_ready, done}), 4'b1110);

    // cfg, len, dev, wait, stop_after, stop_data, tabort
    run_txn(0, 4, 1, 0, -1, 0, 0, "R4");   // plain burst
    run_txn(0, 1, 2, 0, -1, 0, 0, "R4");   // single phase
    run_txn(0, 0, 1, 0, -1, 0, 0, "R4");   // zero length as one
    run_txn(0, 3, 3, 2, -1, 0, 0, "R10");  // wait states
    run_txn(0, 6, 1, 1, -1, 0, 0, "R3");   // long burst with waits
    run_txn(0, 3, 0, 0, -1, 0, 0, "R5");   // nobody claims
    run_txn(0, 2, 5, 0, -1, 0, 0, "R5");   // claim at floor limit
    run_txn(0, 2, 6, 0, -1, 0, 0, "R5");   // one clock too late
    run_txn(7, 2, 7, 0, -1, 0, 0, "R5");   // claim at limit 7
    run_txn(7, 1, 0, 0, -1, 0, 0, "R5");   // abort with frame already high
    run_txn(6, 3, 7, 0, -1, 0, 0, "R5");   // limit 6, late claim
    run_txn(0, 4, 1, 0, 0, 0, 0, "R7");    // retry
    run_txn(0, 1, 3, 0, 0, 0, 0, "R7");    // retry single phase
    run_txn(0, 5, 2, 0, 2, 0, 0, "R8");    // disconnect without data
    run_txn(0, 4, 1, 0, 1, 1, 0, "R8");    // disconnect with data
    run_txn(0, 3, 1, 0, 2, 1, 0, "R8");    // stop on final phase = ok
    run_txn(0, 4, 1, 0, 1, 0, 1, "R6");    // target abort after data
    run_txn(0, 2, 2, 0, 0, 0, 1, "R6");    // target abort no data
    run_txn(0, 2, 1, 0, 1, 0, 1, "R6");    // target abort in final phase
    run_txn(5, 7, 1, 0, -1, 0, 0, "R4");   // long plain burst

    repeat (4) @(negedge clk);
    chk(exp_st_q.size() == 0, "R4", "scoreboard drained", exp_st_q.size(), 0);
    finish_run();
  end
endmodule